// File: doc/BRIEF.md
# Trace Capture Window Controller

This block decides which processor trace words land in a 64-entry trace buffer, and what happens when that buffer runs out of room. A 3-bit select field pairs one of three trigger pulses (address breakpoint, PC breakpoint 0, PC breakpoint 1) as the start event with another as the stop event. Two further selections turn recording off entirely or make it unconditional. Each trace word offered with a valid strobe while the recording window is open is written at the write pointer.

A 2-bit mode field chooses between two behaviours when the buffer fills. The free-running behaviour keeps overwriting the oldest entries. The halting behaviour raises a core-halt request once the 64th entry is written and accepts nothing more until a debug "go" command clears the buffer and releases the core. The other mode bit selects PC-profile recording. In PC-profile modes, and only when the sync-enable bit is set, the block issues a periodic PC-synchronization insertion request. Its interval is a base cycle count that a divide bit can scale by 16.

A debugger reads the buffer oldest-first through a rewind/advance read port. The configuration byte can be written and read back at any time.

Top module: `trace_rec_ctrl`

## Requirements
- R1: The configuration byte holds the sync enable at bit 7, the interval-scale bit at bit 6, a reserved bit 5 that always reads 0, the mode at bits 4:3 (bit 3 = halt on full, bit 4 = PC profile) and the start/stop select at bits 2:0. It is loaded when `cfgWrEn` is high and reads back on `cfgRdData` the next cycle. A write closes any open recording window and restarts the sync interval.
- R2: With select 000 no trace word is captured. With select 001 every valid trace word is captured.
- R3: The selects 010 to 111 open and close the window as follows. Each entry is given as start / stop.
  - 010: address / PC0
  - 011: address / PC1
  - 100: PC0 / address
  - 101: PC1 / address
  - 110: PC1 / PC0
  - 111: PC0 / PC1

  A trigger takes effect for trace words from the following cycle on.
- R4: When the start and stop triggers of the selected pair pulse in the same cycle, the window ends up closed.
- R5: Trigger pulses that arrive while `haltAck` is high change nothing.
- R6: When mode bit 3 is 0, `haltReq` stays low. Once more than 64 words have been captured, the oldest are overwritten and the buffer holds the 64 newest. With 64 or fewer, all are kept.
- R7: When mode bit 3 is 1, `haltReq` rises the cycle after the 64th capture. It holds until `goCmd`, and valid trace words are discarded while it is high.
- R8: `goCmd` empties the buffer, drops `haltReq` the next cycle and resets the write position to entry 0. A trace word offered in the same cycle is discarded.
- R9: A `rdRewind` pulse points the read port at the oldest stored entry. `rdAvail` is high while unread entries remain. Each `rdAdvance` cycle steps to the next newer entry, and the port yields exactly as many entries as are stored.
- R10: `syncReq` pulses for one cycle every SYNC_CYCLES cycles only when bit 7 and mode bit 4 are both 1 and `haltAck` is low. Otherwise it stays low.
- R11: With bit 6 set, the `syncReq` interval is 16 × SYNC_CYCLES cycles.
- R12: After reset, `cfgRdData` is 0 and `haltReq`, `syncReq` and `rdAvail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgWrData | input | 8 | Configuration byte to write |
| cfgRdData | output | 8 | Current configuration byte |
| traceValid | input | 1 | Trace word present this cycle |
| traceData | input | DATA_W | Trace word |
| trigAddr | input | 1 | Address breakpoint pulse |
| trigPc0 | input | 1 | PC breakpoint 0 pulse |
| trigPc1 | input | 1 | PC breakpoint 1 pulse |
| haltAck | input | 1 | Core reports it is halted |
| goCmd | input | 1 | Debug go: clear buffer, release halt |
| haltReq | output | 1 | Core halt request on full buffer |
| rdRewind | input | 1 | Point read port at oldest entry |
| rdAdvance | input | 1 | Step read port to next entry |
| rdData | output | DATA_W | Entry under the read pointer |
| rdAvail | output | 1 | Unread entries remain |
| syncReq | output | 1 | PC-sync insertion request pulse |

## Verification
The bench sweeps all eight select values through one trigger sequence that includes repeated and same-cycle triggers. A wrong decode table or a start-beats-stop priority would therefore leave extra or missing words in the readout. It fills the buffer past 64 entries in both full behaviours. A design that halts in the free mode, wraps in the halting mode, raises the halt one entry early or late, or reads from the wrong oldest entry shows up directly in the ordered readout. It also checks that a "go" in the same cycle as a trace word leaves the buffer empty, and that triggers during `haltAck` are ignored. Sync pulses are timed exactly at both scales, and the bench confirms they never appear when either enabling bit is clear.

// File: rtl/trace_rec_pkg.sv
package trace_rec_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
    logic clear;
    logic rewind;
    logic advance;
  } dpStrobe_t;

  // Trigger vector bit positions: {pc1, pc0, addr}.
  localparam int TRIG_N = 3;

  // Mode bits within the 2-bit mode field.
  localparam int MODE_HALT_BIT = 0;
  localparam int MODE_PROF_BIT = 1;

  function automatic logic [TRIG_N-1:0] startMask(input logic [2:0] sel);
    logic [TRIG_N-1:0] m;
    case (sel)
      3'd2, 3'd3: m = 3'b001;
      3'd4, 3'd7: m = 3'b010;
      3'd5, 3'd6: m = 3'b100;
      default:    m = 3'b000;
    endcase
    return m;
  endfunction

  function automatic logic [TRIG_N-1:0] stopMask(input logic [2:0] sel);
    logic [TRIG_N-1:0] m;
    case (sel)
      3'd2, 3'd6: m = 3'b010;
      3'd3, 3'd7: m = 3'b100;
      3'd4, 3'd5: m = 3'b001;
      default:    m = 3'b000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/trace_rec_dp.sv
module trace_rec_dp
  import trace_rec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              lastSlot,
  output logic [DATA_W-1:0] rdData,
  output logic              rdAvail
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  rdRemain;
  logic              wrapped;

  logic [PTR_W-1:0]  oldestPtr;
  logic [CNT_W-1:0]  storedCnt;

  assign lastSlot  = (wrPtr == PTR_LAST);
  assign oldestPtr = wrapped ? wrPtr : '0;
  assign storedCnt = wrapped ? CNT_FULL : CNT_W'(wrPtr);
  assign rdData    = store[rdPtr];
  assign rdAvail   = (rdRemain != '0);

  // Storage array: no reset needed, contents qualified by pointers.
  always_ff @(posedge clk) begin
    if (strobe.capture) store[wrPtr] <= wrData;
  end

  // Write side.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      wrapped <= 1'b0;
    end else if (strobe.clear) begin
      wrPtr   <= '0;
      wrapped <= 1'b0;
    end else if (strobe.capture) begin
      wrPtr <= lastSlot ? '0 : wrPtr + 1'b1;
      if (lastSlot) wrapped <= 1'b1;
    end
  end

  // Read side.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      rdRemain <= '0;
    end else if (strobe.clear) begin
      rdPtr    <= '0;
      rdRemain <= '0;
    end else if (strobe.rewind) begin
      rdPtr    <= oldestPtr;
      rdRemain <= storedCnt;
    end else if (strobe.advance && rdAvail) begin
      rdPtr    <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      rdRemain <= rdRemain - 1'b1;
    end
  end

endmodule

// File: rtl/trace_sync_timer.sv
module trace_sync_timer #(
  parameter int SYNC_CYCLES = 8,
  parameter int SCALE       = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic scaleUp,
  input  logic restart,
  output logic pulse
);

  localparam int LONG_CYCLES = SYNC_CYCLES * SCALE;
  localparam int W = $clog2(LONG_CYCLES + 1);
  localparam logic [W-1:0] SHORT_LIM = W'(SYNC_CYCLES - 1);
  localparam logic [W-1:0] LONG_LIM  = W'(LONG_CYCLES - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  assign limit = scaleUp ? LONG_LIM : SHORT_LIM;
  assign pulse = enable && (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (restart || !enable) begin
      cnt <= '0;
    end else if (cnt >= limit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/trace_rec_ctl.sv
module trace_rec_ctl
  import trace_rec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgQ,
  input  logic       traceValid,
  input  logic       trigAddr,
  input  logic       trigPc0,
  input  logic       trigPc1,
  input  logic       haltAck,
  input  logic       goCmd,
  input  logic       rdRewind,
  input  logic       rdAdvance,
  input  logic       lastSlot,
  output dpStrobe_t  strobe,
  output logic       haltReq
);

  localparam logic [7:0] CFG_WR_MASK = 8'hDF;

  logic [2:0]        selField;
  logic [1:0]        modeField;
  logic [TRIG_N-1:0] trigVec;
  logic              startHit;
  logic              stopHit;
  logic              recFlag;
  logic              recActive;
  logic              fullHalt;
  logic              capture;
  logic              haltMode;

  assign selField  = cfgQ[2:0];
  assign modeField = cfgQ[4:3];
  assign haltMode  = modeField[MODE_HALT_BIT];

  assign trigVec  = haltAck ? '0 : {trigPc1, trigPc0, trigAddr};
  assign startHit = |(trigVec & startMask(selField));
  assign stopHit  = |(trigVec & stopMask(selField));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWrEn) begin
      cfgQ <= cfgWrData & CFG_WR_MASK;
    end
  end

  // Recording window; stop has priority over start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recFlag <= 1'b0;
    end else if (cfgWrEn) begin
      recFlag <= 1'b0;
    end else if (stopHit) begin
      recFlag <= 1'b0;
    end else if (startHit) begin
      recFlag <= 1'b1;
    end
  end

  always_comb begin
    case (selField)
      3'd0:    recActive = 1'b0;
      3'd1:    recActive = 1'b1;
      default: recActive = recFlag;
    endcase
  end

  assign capture = traceValid && recActive && !fullHalt && !goCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullHalt <= 1'b0;
    end else if (goCmd) begin
      fullHalt <= 1'b0;
    end else if (capture && lastSlot && haltMode) begin
      fullHalt <= 1'b1;
    end
  end

  assign haltReq = fullHalt;

  always_comb begin
    strobe         = '0;
    strobe.capture = capture;
    strobe.clear   = goCmd;
    strobe.rewind  = rdRewind;
    strobe.advance = rdAdvance;
  end

endmodule

// File: rtl/trace_rec_ctrl.sv
module trace_rec_ctrl
  import trace_rec_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 64,
  parameter int SYNC_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              traceValid,
  input  logic [DATA_W-1:0] traceData,
  input  logic              trigAddr,
  input  logic              trigPc0,
  input  logic              trigPc1,
  input  logic              haltAck,
  input  logic              goCmd,
  output logic              haltReq,
  input  logic              rdRewind,
  input  logic              rdAdvance,
  output logic [DATA_W-1:0] rdData,
  output logic              rdAvail,
  output logic              syncReq
);

  dpStrobe_t  strobe;
  logic       lastSlot;
  logic [7:0] cfgQ;
  logic       syncEnable;

  assign cfgRdData  = cfgQ;
  assign syncEnable = cfgQ[7] && cfgQ[3 + MODE_PROF_BIT] && !haltAck;

  trace_rec_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .cfgQ       (cfgQ),
    .traceValid (traceValid),
    .trigAddr   (trigAddr),
    .trigPc0    (trigPc0),
    .trigPc1    (trigPc1),
    .haltAck    (haltAck),
    .goCmd      (goCmd),
    .rdRewind   (rdRewind),
    .rdAdvance  (rdAdvance),
    .lastSlot   (lastSlot),
    .strobe     (strobe),
    .haltReq    (haltReq)
  );

  trace_rec_dp #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (traceData),
    .lastSlot (lastSlot),
    .rdData   (rdData),
    .rdAvail  (rdAvail)
  );

  trace_sync_timer #(
    .SYNC_CYCLES (SYNC_CYCLES),
    .SCALE       (16)
  ) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (syncEnable),
    .scaleUp (cfgQ[6]),
    .restart (cfgWrEn),
    .pulse   (syncReq)
  );

endmodule

// File: rtl/trace_rec_chk.sv
module trace_rec_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] cfgRdData,
  input logic       haltAck,
  input logic       goCmd,
  input logic       haltReq,
  input logic       rdAvail,
  input logic       syncReq
);

  assert_halt_needs_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(cfgRdData[3]));

  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && !goCmd) |=> haltReq);

  assert_go_releases_R8: assert property (@(posedge clk) disable iff (!rstN)
    goCmd |=> !haltReq);

  assert_go_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    goCmd |=> !rdAvail);

  assert_sync_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |-> (cfgRdData[7] && cfgRdData[4] && !haltAck));

  assert_sync_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |=> !syncReq);

  assert_reserved_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdData[5]);

endmodule

bind trace_rec_ctrl trace_rec_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgRdData (cfgRdData),
  .haltAck   (haltAck),
  .goCmd     (goCmd),
  .haltReq   (haltReq),
  .rdAvail   (rdAvail),
  .syncReq   (syncReq)
);

// File: tb/sim_trace_rec_ctrl.sv
module sim_trace_rec_ctrl;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 64;
  localparam int SYNC_CYCLES = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [7:0]        cfgWrData = '0;
  logic [7:0]        cfgRdData;
  logic              traceValid = 1'b0;
  logic [DATA_W-1:0] traceData = '0;
  logic              trigAddr = 1'b0;
  logic              trigPc0 = 1'b0;
  logic              trigPc1 = 1'b0;
  logic              haltAck = 1'b0;
  logic              goCmd = 1'b0;
  logic              haltReq;
  logic              rdRewind = 1'b0;
  logic              rdAdvance = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              rdAvail;
  logic              syncReq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [DATA_W-1:0] model[$];

  always #10 clk = ~clk;

  trace_rec_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_CYCLES(SYNC_CYCLES)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .traceValid(traceValid), .traceData(traceData),
    .trigAddr(trigAddr), .trigPc0(trigPc0), .trigPc1(trigPc1),
    .haltAck(haltAck), .goCmd(goCmd), .haltReq(haltReq),
    .rdRewind(rdRewind), .rdAdvance(rdAdvance), .rdData(rdData),
    .rdAvail(rdAvail), .syncReq(syncReq)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Start/stop table written from the requirement: bit0 addr, bit1 pc0, bit2 pc1.
  function automatic logic [2:0] benchStart(input int sel);
    case (sel)
      2: return 3'b001; 3: return 3'b001; 4: return 3'b010;
      5: return 3'b100; 6: return 3'b100; 7: return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] benchStop(input int sel);
    case (sel)
      2: return 3'b010; 3: return 3'b100; 4: return 3'b001;
      5: return 3'b001; 6: return 3'b010; 7: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic writeCfg(input logic [7:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseGo();
    goCmd = 1'b1;
    @(negedge clk);
    goCmd = 1'b0;
    model.delete();
  endtask

  task automatic pulseTrig(input logic [2:0] v);
    {trigPc1, trigPc0, trigAddr} = v;
    @(negedge clk);
    {trigPc1, trigPc0, trigAddr} = 3'b000;
  endtask

  task automatic sendWord(input logic [DATA_W-1:0] d);
    traceValid = 1'b1; traceData = d;
    @(negedge clk);
    traceValid = 1'b0;
  endtask

  task automatic readCheck(input string req);
    int n = 0;
    rdRewind = 1'b1;
    @(negedge clk);
    rdRewind = 1'b0;
    while (rdAvail && n < DEPTH + 8) begin
      if (n < model.size())
        check(rdData == model[n], req, int'(rdData), int'(model[n]));
      rdAdvance = 1'b1;
      @(negedge clk);
      n++;
    end
    rdAdvance = 1'b0;
    check(n == model.size(), {req, " entry count"}, n, model.size());
  endtask

  task automatic measurePeriod(input int expected, input string req);
    int w = 0;
    int n = 0;
    while (!syncReq && w < 600) begin @(negedge clk); w++; end
    check(syncReq == 1'b1, {req, " first pulse"}, int'(syncReq), 1);
    do begin @(negedge clk); n++; end while (!syncReq && n < 600);
    check(n == expected, {req, " interval"}, n, expected);
  endtask

  task automatic noPulse(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (syncReq) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic printSummary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    printSummary();
    $finish;
  end

  initial begin
    logic [2:0] seq[14];
    seq = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b001, 3'b100, 3'b010,
            3'b111, 3'b001, 3'b010, 3'b100, 3'b011, 3'b110, 3'b101};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    check(cfgRdData == 8'h00, "R12 cfg", int'(cfgRdData), 0);
    check(!haltReq, "R12 haltReq", int'(haltReq), 0);
    check(!syncReq, "R12 syncReq", int'(syncReq), 0);
    check(!rdAvail, "R12 rdAvail", int'(rdAvail), 0);

    // R1 config byte, reserved bit 5 reads 0
    writeCfg(8'hFF);
    check(cfgRdData == 8'hDF, "R1 readback", int'(cfgRdData), 8'hDF);
    writeCfg(8'h5A);
    check(cfgRdData == 8'h5A, "R1 readback", int'(cfgRdData), 8'h5A);

    // R2/R3/R4 sweep of every select value
    for (int sel = 0; sel < 8; sel++) begin
      bit rec;
      writeCfg(8'(sel));
      pulseGo();
      rec = (sel == 1);
      for (int s = 0; s < 14; s++) begin
        pulseTrig(seq[s]);
        if (sel >= 2) begin
          if ((seq[s] & benchStop(sel)) != 0) rec = 0;
          else if ((seq[s] & benchStart(sel)) != 0) rec = 1;
        end
        for (int k = 0; k < 2; k++) begin
          logic [DATA_W-1:0] d;
          d = 16'((sel << 8) | (s << 2) | k);
          sendWord(d);
          if (sel != 0 && rec) model.push_back(d);
        end
      end
      if (sel == 0) readCheck("R2 sel000");
      else if (sel == 1) readCheck("R2 sel001");
      else readCheck("R3 R4 start/stop sweep");
    end

    // R5 triggers ignored while halted
    writeCfg(8'h02);
    pulseGo();
    haltAck = 1'b1; pulseTrig(3'b001); haltAck = 1'b0;
    sendWord(16'hA001);
    pulseTrig(3'b001);
    sendWord(16'hA002); model.push_back(16'hA002);
    haltAck = 1'b1; pulseTrig(3'b010); haltAck = 1'b0;
    sendWord(16'hA003); model.push_back(16'hA003);
    readCheck("R5 halted triggers");

    // R6 free mode: 64 kept intact, then overwrite oldest
    writeCfg(8'h01);
    pulseGo();
    for (int i = 0; i < DEPTH; i++) begin
      sendWord(16'(16'h1000 + i)); model.push_back(16'(16'h1000 + i));
    end
    check(!haltReq, "R6 no halt at 64", int'(haltReq), 0);
    readCheck("R6 exactly 64");
    for (int i = DEPTH; i < DEPTH + 6; i++) begin
      sendWord(16'(16'h1000 + i)); model.push_back(16'(16'h1000 + i));
      void'(model.pop_front());
    end
    check(!haltReq, "R6 no halt after wrap", int'(haltReq), 0);
    readCheck("R6 wrap oldest-first R9");

    // R7 halting mode
    writeCfg(8'h09);
    pulseGo();
    for (int i = 0; i < DEPTH - 1; i++) begin
      sendWord(16'(16'h2000 + i)); model.push_back(16'(16'h2000 + i));
    end
    check(!haltReq, "R7 no halt at 63", int'(haltReq), 0);
    sendWord(16'h203F); model.push_back(16'h203F);
    check(haltReq, "R7 halt at 64", int'(haltReq), 1);
    for (int i = 0; i < 6; i++) sendWord(16'(16'h2100 + i));
    check(haltReq, "R7 halt held", int'(haltReq), 1);
    readCheck("R7 contents kept");

    // R8 go releases and empties
    pulseGo();
    check(!haltReq, "R8 halt released", int'(haltReq), 0);
    readCheck("R8 empty after go");
    sendWord(16'h3000); sendWord(16'h3001);
    goCmd = 1'b1; traceValid = 1'b1; traceData = 16'h3002;
    @(negedge clk);
    goCmd = 1'b0; traceValid = 1'b0;
    model.delete();
    readCheck("R8 same-cycle word dropped");
    sendWord(16'h3003); model.push_back(16'h3003);
    readCheck("R8 write restarts at entry 0");

    // R10/R11 sync requests
    writeCfg(8'h90);
    measurePeriod(SYNC_CYCLES, "R10 profile sync");
    writeCfg(8'h98);
    measurePeriod(SYNC_CYCLES, "R10 halting profile sync");
    writeCfg(8'hD0);
    measurePeriod(SYNC_CYCLES * 16, "R11 scaled sync");
    writeCfg(8'h10);
    noPulse(300, "R10 sync disabled");
    writeCfg(8'h88);
    noPulse(300, "R10 non-profile mode");
    writeCfg(8'h90);
    haltAck = 1'b1;
    noPulse(100, "R10 held while halted");
    haltAck = 1'b0;

    printSummary();
    $finish;
  end

endmodule